// File: doc/BRIEF.md
# Eight-Input Interrupt Priority Controller

This block arbitrates between eight interrupt request lines under a fixed priority order, line 0 highest and line 7 lowest. Each line is either edge triggered or level triggered, chosen by its own bit in a configuration register. A per-line mask blocks a line from being forwarded. When an unmasked request outranks everything already in service, the block raises a single interrupt output toward the processor.

The processor answers with two active-low acknowledge pulses. The first pulse's falling edge picks the winning line and moves it from the request state into the in-service state. During the second pulse the block drives an 8-bit vector made of a programmable 5-bit base and the 3-bit level. If the winning request has gone away by the first falling edge, the block returns the lowest-priority level (7) instead and marks nothing as in service.

Service ends in one of three ways. A command port accepts a non-specific end-of-interrupt, which retires the highest-priority in-service level. The same port accepts a specific end-of-interrupt, which retires the level it names. When automatic mode is enabled, the block retires that level by itself when the second pulse ends. A special mask mode lets masked in-service levels stop blocking lower requests, and non-specific retirement then skips those levels.

Top module: `irq_prio_ctl`

## Requirements
- R1: After reset, no request or in-service state is held, every mask bit is 1, every line is edge triggered, automatic and special mask modes are off, and `int_o` and `vec_oe_o` are 0.
- R2: A line whose trigger bit is 0 raises a request only on a 0-to-1 transition. Once acknowledged, a line that stays high raises no further request.
- R3: A line whose trigger bit is 1 requests while it is high. If it is still high after its in-service level is retired, it requests again. When it drops, the request is withdrawn.
- R4: Priority is fixed, with lower index winning. Outside special mask mode, `int_o` is 1 only while some unmasked request outranks every in-service level.
- R5: A line whose mask bit is 1 is never forwarded, whether it is edge or level triggered.
- R6: At the falling edge of the first acknowledge pulse, the winning line becomes in service and stops requesting. `int_o` is 0 from the next cycle until the sequence ends.
- R7: `vec_o` = {base[4:0], level[2:0]} and `vec_oe_o` = 1 exactly while the second acknowledge pulse is low. Otherwise `vec_oe_o` is 0 and `vec_o` is 0.
- R8: If no request is forwarded at the first falling edge, the vector level is 7 and no in-service bit is set.
- R9: A non-specific end-of-interrupt (`eoi_specific_i` = 0) retires the highest-priority in-service level.
- R10: A specific end-of-interrupt (`eoi_specific_i` = 1) retires only the level on `eoi_level_i`, and leaves other levels in service.
- R11: In special mask mode, in-service levels whose mask bit is 1 neither block lower requests nor are retired by a non-specific end-of-interrupt.
- R12: With automatic mode on, the level acknowledged is retired when the second acknowledge pulse rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| irq_i | input | NUM_LINES | Request lines |
| ack_n_i | input | 1 | Acknowledge pulses, active low, synchronous to clk |
| cfg_we_i | input | 1 | Load all configuration fields below |
| cfg_mask_i | input | NUM_LINES | Mask bits, 1 blocks the line |
| cfg_trig_i | input | NUM_LINES | Trigger bits, 0 edge, 1 level |
| cfg_aeoi_i | input | 1 | Automatic end-of-interrupt enable |
| cfg_smm_i | input | 1 | Special mask mode enable |
| cfg_base_i | input | BASE_W | Vector base |
| eoi_valid_i | input | 1 | End-of-interrupt command strobe |
| eoi_specific_i | input | 1 | 1 specific, 0 non-specific |
| eoi_level_i | input | LVL_W | Level for a specific command |
| int_o | output | 1 | Interrupt to processor |
| vec_o | output | VEC_W | Vector, {base, level} |
| vec_oe_o | output | 1 | Vector valid, high during second pulse |

## Verification
The assertions rely on several assumptions about the inputs:
- The acknowledge line is already synchronous to the clock.
- The acknowledge line always comes as a pair of pulses.
- Each level of the acknowledge line lasts at least one clock.
- End-of-interrupt commands are not issued in the same cycle as a first falling edge.

The stimulus meets all of these assumptions:
- Every input changes one time unit after a rising clock edge.
- Every acknowledge phase is held for whole cycles.
- Commands are only issued between acknowledge sequences.

The default-level case is produced by dropping the line together with the first falling edge. Automatic mode is used only when a real level is acknowledged.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;

   typedef enum logic [1:0] {
      PH_IDLE   = 2'd0,
      PH_FIRST  = 2'd1,
      PH_GAP    = 2'd2,
      PH_SECOND = 2'd3
   } ack_phase_e;

endpackage

// File: rtl/irq_prio_enc.sv
// Finds the lowest set index (highest priority) in a bit vector.
module irq_prio_enc #(
   parameter  int WIDTH = 8,
   localparam int IDX_W = (WIDTH > 1) ? $clog2(WIDTH) : 1
) (
   input  logic [WIDTH-1:0] bits_i,
   output logic             any_o,
   output logic [IDX_W-1:0] idx_o
);

   if (WIDTH < 2) begin : g_width_chk
      $error("irq_prio_enc: WIDTH must be at least 2");
   end

   always_comb begin
      any_o = |bits_i;
      idx_o = '0;
      for (int i = WIDTH - 1; i >= 0; i--) begin
         if (bits_i[i]) idx_o = IDX_W'(i);
      end
   end

endmodule

// File: rtl/irq_trig_latch.sv
// Per-line request capture: edge lines arm on a rising edge, level lines follow the pin.
module irq_trig_latch #(
   parameter int NUM_LINES = 8
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_LINES-1:0] req_i,
   input  logic [NUM_LINES-1:0] trig_i,
   input  logic [NUM_LINES-1:0] take_i,
   output logic [NUM_LINES-1:0] irr_o
);

   for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
      logic req_d;
      logic armed;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            req_d <= 1'b0;
            armed <= 1'b0;
         end else begin
            req_d <= req_i[g];
            if (take_i[g] || !req_i[g]) armed <= 1'b0;
            else if (!req_d)            armed <= 1'b1;
         end
      end

      assign irr_o[g] = trig_i[g] ? req_i[g] : (armed & req_i[g]);

      // Edge line taken into service must not request again while held high.
      assert_edge_once_R2: assert property (@(posedge clk) disable iff (!rst_n)
         (take_i[g] && !trig_i[g]) |=> (!irr_o[g] || trig_i[g]))
         else $error("edge line %0d re-requested after acknowledge", g);
   end

endmodule

// File: rtl/irq_ack_seq.sv
// Tracks the two-pulse acknowledge sequence and latches the granted level.
module irq_ack_seq
   import irq_prio_pkg::*;
#(
   parameter int LVL_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ack_n_i,
   input  logic             win_valid_i,
   input  logic [LVL_W-1:0] win_idx_i,
   output logic             take_o,
   output logic             grant_o,
   output logic             idle_o,
   output logic             end_o,
   output logic             vec_oe_o,
   output logic [LVL_W-1:0] lvl_o
);

   ack_phase_e phase_q;
   logic       ack_q;
   logic       fall, rise;

   assign fall = ack_q & ~ack_n_i;
   assign rise = ~ack_q & ack_n_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ack_q   <= 1'b1;
         phase_q <= PH_IDLE;
         lvl_o   <= '0;
      end else begin
         ack_q <= ack_n_i;
         unique case (phase_q)
            PH_IDLE: if (fall) begin
               phase_q <= PH_FIRST;
               lvl_o   <= win_valid_i ? win_idx_i : '1;
            end
            PH_FIRST:  if (rise) phase_q <= PH_GAP;
            PH_GAP:    if (fall) phase_q <= PH_SECOND;
            PH_SECOND: if (rise) phase_q <= PH_IDLE;
            default:   phase_q <= PH_IDLE;
         endcase
      end
   end

   assign idle_o   = (phase_q == PH_IDLE);
   assign take_o   = idle_o & fall;
   assign grant_o  = take_o & win_valid_i;
   assign end_o    = (phase_q == PH_SECOND) & rise;
   assign vec_oe_o = ~ack_n_i & ((phase_q == PH_GAP) | (phase_q == PH_SECOND));

   // The level latched at the first falling edge stays put until the sequence ends.
   assert_lvl_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (!idle_o && !end_o) |=> $stable(lvl_o))
      else $error("vector level changed inside an acknowledge sequence");

endmodule

// File: rtl/irq_prio_ctl.sv
module irq_prio_ctl #(
   parameter  int NUM_LINES = 8,
   parameter  int BASE_W    = 5,
   localparam int LVL_W     = $clog2(NUM_LINES),
   localparam int VEC_W     = BASE_W + LVL_W
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_LINES-1:0] irq_i,
   input  logic                 ack_n_i,
   input  logic                 cfg_we_i,
   input  logic [NUM_LINES-1:0] cfg_mask_i,
   input  logic [NUM_LINES-1:0] cfg_trig_i,
   input  logic                 cfg_aeoi_i,
   input  logic                 cfg_smm_i,
   input  logic [BASE_W-1:0]    cfg_base_i,
   input  logic                 eoi_valid_i,
   input  logic                 eoi_specific_i,
   input  logic [LVL_W-1:0]     eoi_level_i,
   output logic                 int_o,
   output logic [VEC_W-1:0]     vec_o,
   output logic                 vec_oe_o
);

   if ((NUM_LINES < 2) || (NUM_LINES != (1 << LVL_W))) begin : g_lines_chk
      $error("irq_prio_ctl: NUM_LINES must be a power of two >= 2");
   end
   if (BASE_W < 1) begin : g_base_chk
      $error("irq_prio_ctl: BASE_W must be positive");
   end

   // configuration
   logic [NUM_LINES-1:0] mask_q, trig_q;
   logic                 aeoi_q, smm_q;
   logic [BASE_W-1:0]    base_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mask_q <= '1;
         trig_q <= '0;
         aeoi_q <= 1'b0;
         smm_q  <= 1'b0;
         base_q <= '0;
      end else if (cfg_we_i) begin
         mask_q <= cfg_mask_i;
         trig_q <= cfg_trig_i;
         aeoi_q <= cfg_aeoi_i;
         smm_q  <= cfg_smm_i;
         base_q <= cfg_base_i;
      end
   end

   // request and in-service state
   logic [NUM_LINES-1:0] irr, isr_q, pend, blk;
   logic [NUM_LINES-1:0] isr_set, isr_clr, take_vec;
   logic                 hp_valid, bs_valid, fwd;
   logic [LVL_W-1:0]     hp_idx, bs_idx, lvl;
   logic                 take, grant, idle, seq_end;

   assign take_vec = grant ? (NUM_LINES'(1) << hp_idx) : '0;

   irq_trig_latch #(.NUM_LINES(NUM_LINES)) u_latch (
      .clk    (clk),
      .rst_n  (rst_n),
      .req_i  (irq_i),
      .trig_i (trig_q),
      .take_i (take_vec),
      .irr_o  (irr)
   );

   assign pend = irr & ~mask_q;
   assign blk  = smm_q ? (isr_q & ~mask_q) : isr_q;

   irq_prio_enc #(.WIDTH(NUM_LINES)) u_enc_req (
      .bits_i (pend),
      .any_o  (hp_valid),
      .idx_o  (hp_idx)
   );

   irq_prio_enc #(.WIDTH(NUM_LINES)) u_enc_svc (
      .bits_i (blk),
      .any_o  (bs_valid),
      .idx_o  (bs_idx)
   );

   assign fwd = hp_valid && (!bs_valid || (hp_idx < bs_idx));

   irq_ack_seq #(.LVL_W(LVL_W)) u_ack (
      .clk         (clk),
      .rst_n       (rst_n),
      .ack_n_i     (ack_n_i),
      .win_valid_i (fwd),
      .win_idx_i   (hp_idx),
      .take_o      (take),
      .grant_o     (grant),
      .idle_o      (idle),
      .end_o       (seq_end),
      .vec_oe_o    (vec_oe_o),
      .lvl_o       (lvl)
   );

   always_comb begin
      isr_clr = '0;
      if (eoi_valid_i) begin
         if (eoi_specific_i) isr_clr = NUM_LINES'(1) << eoi_level_i;
         else if (bs_valid)  isr_clr = NUM_LINES'(1) << bs_idx;
      end
      if (seq_end && aeoi_q && bs_valid) isr_clr = isr_clr | (NUM_LINES'(1) << bs_idx);
   end

   assign isr_set = take_vec;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) isr_q <= '0;
      else        isr_q <= (isr_q & ~isr_clr) | isr_set;
   end

   assign int_o = fwd & idle;
   assign vec_o = vec_oe_o ? {base_q, lvl} : '0;

   // ---------------- assertions ----------------
   logic [NUM_LINES-1:0] at_or_above;
   always_comb begin
      for (int i = 0; i < NUM_LINES; i++) at_or_above[i] = (LVL_W'(i) <= hp_idx);
   end

   assert_outrank_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (int_o && !smm_q) |-> ((isr_q & at_or_above) == '0))
      else $error("interrupt raised without outranking in-service levels");

   assert_grant_svc_R6: assert property (@(posedge clk) disable iff (!rst_n)
      grant |=> isr_q[$past(hp_idx)])
      else $error("granted level not in service");

   assert_int_drop_R6: assert property (@(posedge clk) disable iff (!rst_n)
      take |=> !int_o)
      else $error("interrupt output still high after first acknowledge");

   assert_default_noset_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (take && !fwd) |=> ((isr_q & ~$past(isr_q)) == '0))
      else $error("default vector set an in-service bit");

   assert_ns_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (eoi_valid_i && !eoi_specific_i && bs_valid && !grant) |=> !isr_q[$past(bs_idx)])
      else $error("non-specific command left its level in service");

   assert_spec_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (eoi_valid_i && eoi_specific_i && !grant) |=> !isr_q[$past(eoi_level_i)])
      else $error("specific command left its level in service");

   assert_mask_block_R5: assert property (@(posedge clk) disable iff (!rst_n)
      int_o |-> !mask_q[hp_idx])
      else $error("masked line forwarded");

   assert_auto_clear_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (seq_end && aeoi_q && bs_valid && !grant) |=> !isr_q[$past(bs_idx)])
      else $error("automatic retirement missed");

endmodule

// File: tb/tb_irq_prio_ctl.sv
`timescale 1ns/1ps
module tb_irq_prio_ctl;

   localparam logic [4:0] BASE = 5'h15;

   logic       clk = 1'b0;
   logic       rst_n;
   logic [7:0] irq;
   logic       ack_n;
   logic       cfg_we;
   logic [7:0] cfg_mask, cfg_trig;
   logic       cfg_aeoi, cfg_smm;
   logic [4:0] cfg_base;
   logic       eoi_valid, eoi_specific;
   logic [2:0] eoi_level;
   logic       int_o;
   logic [7:0] vec;
   logic       vec_oe;

   int nchk  = 0;
   int nfail = 0;
   logic [7:0] exp_q[$];
   logic       oe_prev = 1'b0;

   always #2.5 clk = ~clk;

   irq_prio_ctl dut (
      .clk(clk), .rst_n(rst_n), .irq_i(irq), .ack_n_i(ack_n),
      .cfg_we_i(cfg_we), .cfg_mask_i(cfg_mask), .cfg_trig_i(cfg_trig),
      .cfg_aeoi_i(cfg_aeoi), .cfg_smm_i(cfg_smm), .cfg_base_i(cfg_base),
      .eoi_valid_i(eoi_valid), .eoi_specific_i(eoi_specific), .eoi_level_i(eoi_level),
      .int_o(int_o), .vec_o(vec), .vec_oe_o(vec_oe)
   );

   task automatic step();
      @(posedge clk); #1;
   endtask

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      nchk++;
      if (act !== exp) begin
         nfail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic cfg(input logic [7:0] m, input logic [7:0] t, input logic a, input logic s);
      cfg_we = 1'b1; cfg_mask = m; cfg_trig = t; cfg_aeoi = a; cfg_smm = s; cfg_base = BASE;
      step();
      cfg_we = 1'b0;
   endtask

   task automatic eoi(input logic spec, input logic [2:0] lvl);
      eoi_valid = 1'b1; eoi_specific = spec; eoi_level = lvl;
      step();
      eoi_valid = 1'b0;
   endtask

   // driver: pushes the expected vector and runs both acknowledge pulses
   task automatic ack(input logic [2:0] lvl);
      exp_q.push_back({BASE, lvl});
      ack_n = 1'b0; step();
      chk("R6 int low after first pulse", {7'd0, int_o}, 8'd0);
      ack_n = 1'b1; step();
      chk("R7 no vector between pulses", {7'd0, vec_oe}, 8'd0);
      ack_n = 1'b0; step(); step();
      ack_n = 1'b1; #1;
      chk("R7 vector released after second pulse", {vec_oe, vec}, 9'd0);
      step();
   endtask

   // monitor: compares each vector as it appears
   always @(negedge clk) begin
      if (vec_oe && !oe_prev) begin
         nchk++;
         if (exp_q.size() == 0) begin
            nfail++;
            $display("FAIL R7 unexpected vector: actual %h expected none", vec);
         end else begin
            logic [7:0] e;
            e = exp_q.pop_front();
            if (vec !== e) begin
               nfail++;
               $display("FAIL R7/R8 vector: actual %h expected %h", vec, e);
            end
         end
      end
      oe_prev <= vec_oe;
   end

   initial begin
      #(200000 * 5);
      nfail++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
   end

   initial begin
      rst_n = 1'b0; irq = '0; ack_n = 1'b1; cfg_we = 1'b0; cfg_mask = '0; cfg_trig = '0;
      cfg_aeoi = 1'b0; cfg_smm = 1'b0; cfg_base = '0; eoi_valid = 1'b0;
      eoi_specific = 1'b0; eoi_level = '0;
      repeat (3) step();
      chk("R1 outputs in reset", {6'd0, int_o, vec_oe}, 8'd0);
      rst_n = 1'b1; step();

      // R1/R5: every line masked after reset
      irq[3] = 1'b1; step(); step();
      chk("R1 all masked after reset", {7'd0, int_o}, 8'd0);
      irq[3] = 1'b0; step();

      // R5: mask one line only
      cfg(8'h08, 8'h00, 1'b0, 1'b0);
      irq[3] = 1'b1; step();
      chk("R5 masked line blocked", {7'd0, int_o}, 8'd0);
      cfg(8'h00, 8'h00, 1'b0, 1'b0);
      chk("R5 unmasked line forwarded", {7'd0, int_o}, 8'd1);
      irq[3] = 1'b0; step();

      // R2: edge line, held high, single request
      irq[4] = 1'b1; step();
      chk("R2 edge request", {7'd0, int_o}, 8'd1);
      ack(3'd4);
      chk("R6 in service blocks same line", {7'd0, int_o}, 8'd0);
      eoi(1'b0, 3'd0);
      chk("R2 held edge line no second request", {7'd0, int_o}, 8'd0);
      irq[4] = 1'b0; step();

      // R4/R9: priority and non-specific retirement
      irq[6] = 1'b1; irq[2] = 1'b1; step();
      ack(3'd2);
      chk("R4 lower request blocked", {7'd0, int_o}, 8'd0);
      irq[1] = 1'b1; step();
      chk("R4 higher request forwarded", {7'd0, int_o}, 8'd1);
      ack(3'd1);
      eoi(1'b0, 3'd0);
      chk("R9 retires level 1 only", {7'd0, int_o}, 8'd0);
      eoi(1'b0, 3'd0);
      chk("R9 retires level 2", {7'd0, int_o}, 8'd1);
      ack(3'd6);

      // R10: specific retirement
      irq[7] = 1'b1; step();
      eoi(1'b1, 3'd3);
      chk("R10 other level untouched", {7'd0, int_o}, 8'd0);
      eoi(1'b1, 3'd6);
      chk("R10 named level retired", {7'd0, int_o}, 8'd1);
      ack(3'd7);
      eoi(1'b1, 3'd7);
      irq = '0; step();

      // R3: level line
      cfg(8'h00, 8'h01, 1'b0, 1'b0);
      irq[0] = 1'b1; #1;
      chk("R3 level request", {7'd0, int_o}, 8'd1);
      step();
      ack(3'd0);
      eoi(1'b0, 3'd0);
      chk("R3 level still high re-requests", {7'd0, int_o}, 8'd1);
      irq[0] = 1'b0; #1;
      chk("R3 level withdrawn", {7'd0, int_o}, 8'd0);
      step();
      cfg(8'h00, 8'h00, 1'b0, 1'b0);

      // R8: request withdrawn before first falling edge
      irq[5] = 1'b1; step();
      chk("R8 request present", {7'd0, int_o}, 8'd1);
      irq[5] = 1'b0;
      ack(3'd7);
      irq[7] = 1'b1; step();
      chk("R8 no level left in service", {7'd0, int_o}, 8'd1);
      ack(3'd7);
      eoi(1'b0, 3'd0);
      irq = '0; step();

      // R11: special mask mode
      cfg(8'h00, 8'h00, 1'b0, 1'b1);
      irq[2] = 1'b1; step();
      ack(3'd2);
      cfg(8'h04, 8'h00, 1'b0, 1'b1);
      irq[4] = 1'b1; step();
      chk("R11 masked in-service does not block", {7'd0, int_o}, 8'd1);
      ack(3'd4);
      eoi(1'b0, 3'd0);
      irq[5] = 1'b1; step();
      chk("R11 non-specific skipped masked level", {7'd0, int_o}, 8'd1);
      ack(3'd5);
      eoi(1'b0, 3'd0);
      cfg(8'h00, 8'h00, 1'b0, 1'b0);
      eoi(1'b1, 3'd2);
      irq = '0; step();
      chk("R4 idle after clean-up", {7'd0, int_o}, 8'd0);

      // R12: automatic retirement
      cfg(8'h00, 8'h00, 1'b1, 1'b0);
      irq[3] = 1'b1; step();
      ack(3'd3);
      irq[6] = 1'b1; step();
      chk("R12 level retired automatically", {7'd0, int_o}, 8'd1);
      ack(3'd6);
      irq = '0; step();
      cfg(8'h00, 8'h00, 1'b0, 1'b0);
      chk("R12 nothing pending at end", {7'd0, int_o}, 8'd0);
      chk("R7 every vector observed", 8'(exp_q.size()), 8'd0);

      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
   end

endmodule